// File: doc/BRIEF.md
# Lane-Selected Word Memory

This block is a synthesizable, clock-edge model of a static word memory. Each word is split into byte-wide lanes, and every lane has its own active-low select. There is one active-low write strobe and one active-low output-enable that all lanes share. Per lane, the mode is worked out from the lane's select and the two shared strobes.

- A selected lane stores its byte when the write strobe is low.
- A selected lane presents its byte when the write strobe is high and the output-enable is low.

The pad high-impedance state is modelled as a per-lane drive flag. A lane whose flag is low returns zero on its data bits. A standby pin reports when no lane is selected.

The depth is set by the address-width parameter. A small default keeps simulation cheap, and 19 bits gives the full-size part.

The memory uses plain strobe pins, as a static memory does, and has no handshake. Every cycle is accepted, so no back-pressure exists.

- Writes take effect at the rising clock edge on which the inputs are sampled.
- Read data and drive flags are registered: they appear after the rising edge that samples the read request and stay until the next edge.

Top module: `sram_lanes`

## Requirements
- R1: Lane 0 is data bits 7:0 gated by `sel_n[0]`, lane 1 is bits 15:8 gated by `sel_n[1]`, and lane 2 is bits 23:16 gated by `sel_n[2]`.
- R2: At a rising edge where `sel_n[l]` is 0 and `we_n` is 0, lane l of `wdata` is stored at `addr`, whatever the level of `oe_n`. After that edge, `lane_oe` is 0 for every lane.
- R3: A write leaves the lanes whose select is 1 unchanged at that address.
- R4: At a rising edge where `sel_n[l]` is 0, `we_n` is 1 and `oe_n` is 0, the following are true after that edge: `lane_oe[l]` is 1, and lane l of `rdata` equals the stored byte at `addr`.
- R5: A lane that is not read at an edge has `lane_oe[l]` at 0 and its `rdata` bits at 0 after that edge. This covers a deselected lane, `oe_n` high during a read, and any write.
- R6: `standby` is 1 exactly when all three selects are 1, independent of `we_n` and `oe_n`. No lane is written or driven in that state.
- R7: While `rst_n` is 0, `rdata` is 0 and `lane_oe` is 0.
- R8: A read of an address in the cycle right after a write to it returns the newly written bytes.
- R9: With all selects 0, one cycle writes or reads all 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| sel_n | input | 3 | Active-low select, one bit per lane |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Registered read data, zero in undriven lanes |
| lane_oe | output | 3 | Registered per-lane drive flag |
| standby | output | 1 | High when no lane is selected |

## Verification
A registered read and a storage write can meet at one address on neighbouring edges. The bench provokes this in two ways:

- It writes a word and reads it back on the next cycle.
- It reads an address and then writes it, so that the previous read data is still being presented while the write is accepted.

A queue scoreboard holds the expected bytes for every cycle, computed from a shadow array. The read-after-write must show the new bytes, and the cycle after a write must show no lane driven.

// File: rtl/sram_lanes_pkg.sv
package sram_lanes_pkg;
  typedef enum logic [1:0] {
    LM_OFF   = 2'd0,
    LM_WRITE = 2'd1,
    LM_READ  = 2'd2,
    LM_MUTE  = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
  import sram_lanes_pkg::*;
(
  input  logic       sel_n,
  input  logic       we_n,
  input  logic       oe_n,
  output lane_mode_e mode
);
  always_comb begin
    if (sel_n)      mode = LM_OFF;
    else if (!we_n) mode = LM_WRITE;
    else if (!oe_n) mode = LM_READ;
    else            mode = LM_MUTE;
  end
endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata,
  output logic              drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      drive <= 1'b0;
    end else begin
      drive <= rd;
      rdata <= rd ? mem[addr] : '0;
    end
  end
endmodule

// File: rtl/sram_lanes.sv
module sram_lanes
  import sram_lanes_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 3,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          sel_n,
  input  logic                      we_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic [LANES-1:0]          lane_oe,
  output logic                      standby
);
  assign standby = &sel_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_mode_e mode;

    sram_lane_decode u_dec (
      .sel_n (sel_n[l]),
      .we_n  (we_n),
      .oe_n  (oe_n),
      .mode  (mode)
    );

    sram_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (mode == LM_WRITE),
      .rd    (mode == LM_READ),
      .addr  (addr),
      .wdata (wdata[l*LANE_W +: LANE_W]),
      .rdata (rdata[l*LANE_W +: LANE_W]),
      .drive (lane_oe[l])
    );
  end
endmodule

// File: rtl/sram_lanes_chk.sv
module sram_lanes_chk #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES-1:0]        sel_n,
  input logic                    we_n,
  input logic                    oe_n,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic [LANES-1:0]        lane_oe,
  input logic                    standby
);
  logic [LANES-1:0]        rd_req;
  logic [LANES*LANE_W-1:0] drive_mask;

  assign rd_req = ~sel_n & {LANES{we_n & ~oe_n}};

  always_comb begin
    for (int l = 0; l < LANES; l++)
      drive_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_oe[l]}};
  end

  // R4: drive flags follow the read request of the previous edge
  assert_read_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> lane_oe == $past(rd_req));

  // R5: undriven lanes return zero
  assert_quiet_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~drive_mask) == '0);

  // R2: nothing is driven after a write cycle
  assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> lane_oe == '0);

  // R6: standby leaves every lane undriven
  assert_standby_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> lane_oe == '0);

  // R6: standby pin matches all selects high
  assert_standby_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    standby == (sel_n == '1));
endmodule

bind sram_lanes sram_lanes_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_n   (sel_n),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .rdata   (rdata),
  .lane_oe (lane_oe),
  .standby (standby)
);

// File: tb/tb_sram_lanes.sv
module tb_sram_lanes;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel_n = 3'b111;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic [2:0]  lane_oe;
  logic        standby;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [23:0] shadow [DEPTH];
  logic [2:0]  q_oe [$];
  logic [23:0] q_dat [$];
  string       q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lanes #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .lane_oe(lane_oe),
    .standby(standby)
  );

  function automatic logic [23:0] pat(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {~b, b ^ 8'h3C, b + 8'd17};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] s, input logic w, input logic o,
                    input int a, input logic [23:0] d, input string tag);
    logic [2:0]  eo;
    logic [23:0] ed;
    @(negedge clk);
    sel_n = s; we_n = w; oe_n = o; addr = ADDR_W'(a); wdata = d;
    eo = '0; ed = '0;
    for (int l = 0; l < 3; l++) begin
      if (!s[l] && w && !o) begin
        eo[l] = 1'b1;
        ed[l*8 +: 8] = shadow[a][l*8 +: 8];
      end
      if (!s[l] && !w) shadow[a][l*8 +: 8] = d[l*8 +: 8];
    end
    q_oe.push_back(eo); q_dat.push_back(ed); q_tag.push_back(tag);
    #1;
    check(standby === (s == 3'b111), "R6 standby pin", {23'd0, standby},
          {23'd0, s == 3'b111});
  endtask

  // monitor: outputs after each edge reflect the request sampled there
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_oe.size() > 0) begin
        logic [2:0]  eo;
        logic [23:0] ed;
        string       t;
        eo = q_oe.pop_front(); ed = q_dat.pop_front(); t = q_tag.pop_front();
        check(lane_oe === eo, {t, " lane_oe"}, {21'd0, lane_oe}, {21'd0, eo});
        check(rdata === ed, {t, " rdata"}, rdata, ed);
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 'x;
    repeat (3) @(posedge clk);
    #1;
    check(rdata === 24'd0 && lane_oe === 3'd0, "R7 reset outputs",
          rdata, 24'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R9: full writes to every location, oe_n toggled to show it is ignored
    for (int a = 0; a < DEPTH; a++) op(3'b000, 1'b0, 1'(a), a, pat(a), "R2 R9 full write");
    // R4 R9: full reads of every location
    for (int a = 0; a < DEPTH; a++) op(3'b000, 1'b1, 1'b0, a, 24'h0, "R4 R9 full read");

    // R3 R1: single-lane writes then full reads
    op(3'b110, 1'b0, 1'b1, 5, 24'hABCDEF, "R3 lane0 write");
    op(3'b000, 1'b1, 1'b0, 5, 24'h0, "R3 R1 read after lane0 write");
    op(3'b011, 1'b0, 1'b0, 6, 24'h123456, "R3 lane2 write");
    op(3'b000, 1'b1, 1'b0, 6, 24'h0, "R3 R1 read after lane2 write");
    op(3'b101, 1'b0, 1'b1, 7, 24'h00FF00, "R3 lane1 write");
    op(3'b000, 1'b1, 1'b0, 7, 24'h0, "R3 R1 read after lane1 write");

    // R1 R5: single-lane reads
    op(3'b110, 1'b1, 1'b0, 9, 24'h0, "R1 R5 lane0 read");
    op(3'b101, 1'b1, 1'b0, 9, 24'h0, "R1 R5 lane1 read");
    op(3'b011, 1'b1, 1'b0, 9, 24'h0, "R1 R5 lane2 read");
    op(3'b010, 1'b1, 1'b0, 9, 24'h0, "R1 R5 lanes0+2 read");

    // R5: selected but output enable high
    op(3'b000, 1'b1, 1'b1, 9, 24'h0, "R5 oe_n high");

    // R6: standby with strobes low writes nothing
    op(3'b111, 1'b0, 1'b0, 10, 24'hFFFFFF, "R6 standby write attempt");
    op(3'b111, 1'b1, 1'b0, 10, 24'h0, "R6 standby read attempt");
    op(3'b000, 1'b1, 1'b0, 10, 24'h0, "R6 R3 contents kept");

    // R8: write then read next cycle, and read then write
    op(3'b000, 1'b0, 1'b1, 20, 24'h5A5A5A, "R8 write");
    op(3'b000, 1'b1, 1'b0, 20, 24'h0, "R8 read next cycle");
    op(3'b000, 1'b0, 1'b0, 20, 24'hC3C3C3, "R8 R2 write after read");
    op(3'b000, 1'b1, 1'b0, 20, 24'h0, "R8 read new");
    op(3'b111, 1'b1, 1'b1, 0, 24'h0, "R6 idle");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    summary();
  end
endmodule